// File: doc/BRIEF.md
# Parallel Bus Register Access Interface

This block sits between a host and a data-converter core. The host reaches it over a 16-bit parallel bus. A mode input picks one of two transfer styles. In word mode every access moves 16 bits in one go. In byte mode an access moves two bytes on the low eight data lines, always low byte first. In byte mode, data line 8 of the incoming bus marks which byte of a write is being presented.

Writes are routed by the two top bits of the assembled word. The remaining 14 bits land in the control, test or calibration register. Reads are routed differently. The source is chosen by a two-bit selector that lives in control-register bits 7:6. That selector stays in force until a later control write replaces it, so the control register itself can never be read back. Converter data and status come in as input ports from the core. The stored control, test and calibration values go out as ports to the core.

Top module: `pbus_regif`

## Requirements
- R1: After reset, the control, test and calibration outputs are zero. The bus output is zero with the enable low, both byte phases point at the low byte, and a read returns converter data.
- R2: In word mode, a write strobe whose bus bits 15:14 equal 11 stores bus bits 13:0 into the control register. The new value is visible on `ctrl_out` after the sampling clock edge.
- R3: A committed word with bits 15:14 equal to 01 stores its 14 low bits into the test register. With 10, it stores them into the calibration register.
- R4: A committed word with bits 15:14 equal to 00 leaves all three stored registers unchanged.
- R5: In byte mode, a strobe with bus bit 8 low captures bus bits 7:0 as the low byte and changes no register. The next strobe with bus bit 8 high supplies bus bits 7:0 as bits 15:8 and commits the whole word.
- R6: In byte mode, a high-byte strobe (bus bit 8 high) that arrives with no captured low byte pending is ignored.
- R7: Control bits 7:6 choose the read source. 00 returns {4'b0, 12-bit converter data}, 01 returns {2'b0, test}, 10 returns {2'b0, calibration} and 11 returns the 16-bit status input.
- R8: The read selector keeps its value across any number of reads and across writes to other registers. Only a control write changes it.
- R9: Read data is registered. A read enable sampled at one clock edge raises `bus_oe` and presents the data after that edge. Without a read enable, `bus_oe` is low and `bus_out` is zero.
- R10: In byte mode, successive reads return the low byte of the selected word and then its high byte, each on bits 7:0 with bits 15:8 zero. After the high byte, the sequence starts again at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes and enables are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1: 16-bit transfers, 0: two byte transfers |
| wr_strobe | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read enable |
| bus_in | input | 16 | Host write data; bit 8 is the high-byte marker in byte mode |
| bus_out | output | 16 | Registered read data, zero when not driving |
| bus_oe | output | 1 | High while read data is presented |
| conv_data | input | 12 | Latest conversion result from the core |
| status_in | input | 16 | Status word from the core |
| ctrl_out | output | 14 | Stored control register |
| test_out | output | 14 | Stored test register |
| cal_out | output | 14 | Stored calibration register |

## Verification
Word writes are sent to each of the four address codes, and each result is checked on all three register outputs. This confirms that routing goes by the top bits and that code 00 falls through. Reads are repeated under every selector value, with writes to other registers mixed in between. Those patterns separate a sticky selector from one that follows the last write address, and they also show the zero padding for each source. Byte sequences cover the normal low-then-high order, a stray high byte with nothing pending, and three back-to-back byte reads. These tell a correct phase flag apart from one that never wraps or that commits too early.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int unsigned BUS_W   = 16;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned REG_W   = BUS_W - ADDR_W;
    localparam int unsigned BYTE_W  = BUS_W / 2;
    localparam int unsigned CONV_W  = 12;
    localparam int unsigned HBEN_BIT = BYTE_W;
    localparam int unsigned RSEL_LSB = 6;

    typedef enum logic [ADDR_W-1:0] {
        WA_NONE = 2'b00,
        WA_TEST = 2'b01,
        WA_CAL  = 2'b10,
        WA_CTRL = 2'b11
    } wr_addr_e;

    typedef enum logic [1:0] {
        RS_CONV = 2'b00,
        RS_TEST = 2'b01,
        RS_CAL  = 2'b10,
        RS_STAT = 2'b11
    } rd_sel_e;

    typedef struct packed {
        logic              hi_pending;
        logic [BYTE_W-1:0] low_byte;
    } asm_state_t;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] test;
        logic [REG_W-1:0] cal;
    } reg_state_t;

    typedef struct packed {
        logic             oe;
        logic             hi_next;
        logic [BUS_W-1:0] data;
    } rd_state_t;
endpackage

// File: rtl/pbus_wr_assemble.sv
module pbus_wr_assemble
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_mode,
    input  logic             wr_strobe,
    input  logic [BUS_W-1:0] bus_in,
    output logic             commit,
    output logic [BUS_W-1:0] word
);
    asm_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        word   = bus_in;
        if (word_mode) begin
            st_d.hi_pending = 1'b0;
            commit          = wr_strobe;
        end else if (wr_strobe) begin
            if (!bus_in[HBEN_BIT]) begin
                st_d.low_byte   = bus_in[BYTE_W-1:0];
                st_d.hi_pending = 1'b1;
            end else if (st_q.hi_pending) begin
                commit          = 1'b1;
                word            = {bus_in[BYTE_W-1:0], st_q.low_byte};
                st_d.hi_pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pbus_reg_file.sv
module pbus_reg_file
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [BUS_W-1:0] word,
    output logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] test,
    output logic [REG_W-1:0] cal
);
    reg_state_t st_d, st_q;
    wr_addr_e   addr;

    assign addr = wr_addr_e'(word[BUS_W-1 -: ADDR_W]);

    always_comb begin
        st_d = st_q;
        if (commit) begin
            unique case (addr)
                WA_TEST: st_d.test = word[REG_W-1:0];
                WA_CAL:  st_d.cal  = word[REG_W-1:0];
                WA_CTRL: st_d.ctrl = word[REG_W-1:0];
                default: st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;
    assign test = st_q.test;
    assign cal  = st_q.cal;
endmodule

// File: rtl/pbus_rd_path.sv
module pbus_rd_path
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic [CONV_W-1:0] conv_data,
    input  logic [BUS_W-1:0]  status_in,
    input  logic [REG_W-1:0]  test,
    input  logic [REG_W-1:0]  cal,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe
);
    localparam int unsigned CONV_PAD = BUS_W - CONV_W;
    localparam int unsigned REG_PAD  = BUS_W - REG_W;

    rd_state_t        st_d, st_q;
    logic [BUS_W-1:0] src_word;

    always_comb begin
        unique case (rd_sel_e'(rd_sel))
            RS_CONV: src_word = {{CONV_PAD{1'b0}}, conv_data};
            RS_TEST: src_word = {{REG_PAD{1'b0}}, test};
            RS_CAL:  src_word = {{REG_PAD{1'b0}}, cal};
            default: src_word = status_in;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.oe   = rd_en;
        st_d.data = '0;
        if (word_mode) st_d.hi_next = 1'b0;
        if (rd_en) begin
            if (word_mode) begin
                st_d.data = src_word;
            end else begin
                st_d.data    = st_q.hi_next ? {{BYTE_W{1'b0}}, src_word[BUS_W-1:BYTE_W]}
                                            : {{BYTE_W{1'b0}}, src_word[BYTE_W-1:0]};
                st_d.hi_next = !st_q.hi_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_out = st_q.data;
    assign bus_oe  = st_q.oe;
endmodule

// File: rtl/pbus_regif.sv
module pbus_regif
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              wr_strobe,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_oe,
    input  logic [CONV_W-1:0] conv_data,
    input  logic [BUS_W-1:0]  status_in,
    output logic [REG_W-1:0]  ctrl_out,
    output logic [REG_W-1:0]  test_out,
    output logic [REG_W-1:0]  cal_out
);
    logic             commit;
    logic [BUS_W-1:0] word;
    logic [1:0]       rd_sel;

    pbus_wr_assemble u_asm (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_strobe(wr_strobe),
        .bus_in(bus_in), .commit(commit), .word(word)
    );

    pbus_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
        .ctrl(ctrl_out), .test(test_out), .cal(cal_out)
    );

    assign rd_sel = ctrl_out[RSEL_LSB +: 2];

    pbus_rd_path u_rd (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .rd_en(rd_en),
        .rd_sel(rd_sel), .conv_data(conv_data), .status_in(status_in),
        .test(test_out), .cal(cal_out), .bus_out(bus_out), .bus_oe(bus_oe)
    );
endmodule

// File: rtl/pbus_regif_chk.sv
module pbus_regif_chk
    import pbus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              word_mode,
    input logic              wr_strobe,
    input logic              rd_en,
    input logic [BUS_W-1:0]  bus_in,
    input logic [BUS_W-1:0]  bus_out,
    input logic              bus_oe,
    input logic [REG_W-1:0]  ctrl_out,
    input logic [REG_W-1:0]  test_out,
    input logic [REG_W-1:0]  cal_out
);
    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && word_mode && bus_in[15:14] == 2'b11) |=> ctrl_out == $past(bus_in[REG_W-1:0]));

    assert_test_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && word_mode && bus_in[15:14] == 2'b01) |=> test_out == $past(bus_in[REG_W-1:0]));

    assert_null_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && word_mode && bus_in[15:14] == 2'b00)
        |=> ($stable(ctrl_out) && $stable(test_out) && $stable(cal_out)));

    assert_sel_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |=> $stable(ctrl_out));

    assert_conv_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word_mode && ctrl_out[7:6] == 2'b00) |=> bus_out[15:12] == 4'h0);

    assert_oe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_oe);

    assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!bus_oe && bus_out == '0));

    assert_byte_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !word_mode) |=> bus_out[15:8] == 8'h00);
endmodule

bind pbus_regif pbus_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_strobe(wr_strobe),
    .rd_en(rd_en), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ctrl_out(ctrl_out), .test_out(test_out), .cal_out(cal_out)
);

// File: tb/sim_pbus_regif.sv
module sim_pbus_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b1;
    logic        wr_strobe = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_oe;
    logic [11:0] conv_data = 12'hABC;
    logic [15:0] status_in = 16'hF00D;
    logic [13:0] ctrl_out, test_out, cal_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        string       req;
        logic [15:0] val;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    pbus_regif u0 (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_strobe(wr_strobe),
        .rd_en(rd_en), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .conv_data(conv_data), .status_in(status_in),
        .ctrl_out(ctrl_out), .test_out(test_out), .cal_out(cal_out)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_word(logic [15:0] v);
        @(negedge clk);
        word_mode = 1'b1; bus_in = v; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic wr_byte(logic hben, logic [7:0] b);
        @(negedge clk);
        word_mode = 1'b0; bus_in = {7'b0, hben, b}; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic rd(string req, logic [15:0] exp);
        exp_t e;
        e.req = req; e.val = exp;
        @(negedge clk);
        rd_en = 1'b1;
        exp_q.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && bus_oe) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R9: unexpected read data actual %h expected none", bus_out);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, bus_out, e.val);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 oe", {15'b0, bus_oe}, 16'h0);
        check("R1 bus", bus_out, 16'h0);
        check("R1 ctrl", {2'b0, ctrl_out}, 16'h0);
        rst_n = 1'b1;
        rd("R1 R7 conv", 16'h0ABC);

        // R3: test and calibration writes
        wr_word(16'h4000 | 16'h1234);
        check("R3 test", {2'b0, test_out}, 16'h1234);
        wr_word(16'h8000 | 16'h2AAA);
        check("R3 cal", {2'b0, cal_out}, 16'h2AAA);

        // R4: address 00 is ignored
        wr_word(16'h3FFF);
        check("R4 ctrl", {2'b0, ctrl_out}, 16'h0);
        check("R4 test", {2'b0, test_out}, 16'h1234);
        check("R4 cal", {2'b0, cal_out}, 16'h2AAA);

        // R2: control write, selector 01
        wr_word(16'hC000 | 16'h0040);
        check("R2 ctrl", {2'b0, ctrl_out}, 16'h0040);
        rd("R7 test", 16'h1234);
        rd("R8 repeat", 16'h1234);
        wr_word(16'h8000 | 16'h0155);
        rd("R8 after cal write", 16'h1234);

        wr_word(16'hC000 | 16'h0080);
        rd("R7 cal", 16'h0155);
        wr_word(16'hC000 | 16'h00C0);
        rd("R7 status", 16'hF00D);

        // R5: byte-mode write to test
        wr_byte(1'b0, 8'h67);
        check("R5 no early commit", {2'b0, test_out}, 16'h1234);
        wr_byte(1'b1, 8'h45);
        check("R5 byte commit", {2'b0, test_out}, 16'h0567);

        // R6: stray high byte ignored
        wr_byte(1'b1, 8'hC0);
        check("R6 stray high", {2'b0, ctrl_out}, 16'h00C0);

        // byte write to ctrl selecting calibration
        wr_byte(1'b0, 8'h80);
        wr_byte(1'b1, 8'hC0);
        check("R5 ctrl bytes", {2'b0, ctrl_out}, 16'h0080);

        // R10: byte reads low then high then low
        rd("R10 low", 16'h0055);
        rd("R10 high", 16'h0001);
        rd("R10 wrap", 16'h0055);

        repeat (3) @(negedge clk);
        check("R9 queue drained", 16'(exp_q.size()), 16'h0);
        check("R9 idle oe", {15'b0, bus_oe}, 16'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule